// File: doc/BRIEF.md
# Programmable Synthesizer Divider Chain

This block contains the digital dividers of a frequency-synthesis tuning loop. One input carries the oscillator after an external fixed divide-by-8 stage. It arrives as a single-cycle tick in the system clock domain. A 15-bit programmable divider counts these ticks down by a ratio held in a register. A second input carries crystal ticks. A fixed divider turns them into the comparison reference. With a 4 MHz crystal and the default divide by 512, the reference is 7.8125 kHz. Because of the divide-by-8 stage in front, the tuning step is eight times that, 62.5 kHz.

Both divided outputs are square waves, and their falling edge marks the end of each cycle, so a phase detector can compare the two edges. A general-purpose output either drives a software-chosen level or, with the test select set, mirrors the divided oscillator signal so it can be observed. A ratio written over the control path is held pending and takes effect only at the next terminal count, so no divide cycle is ever cut short.

Top module: `synth_div_chain`

## Requirements
- R1: A synchronous reset sets the programmable counter to 255, sets the active and pending ratios to 256 and sets the reference counter to 511. In that state `div_out` and `ref_out` are 0.
- R2: For an active ratio N, `div_out` has a period of exactly N `osc_tick` pulses. It is 1 during the last floor(N/2) ticks of each period and falls on the tick that ends the period.
- R3: A ratio written through `ratio_wr`/`ratio_in` (15-bit unsigned) that is below 256 is stored as 256. Values from 256 through 32767 are stored unchanged.
- R4: A written ratio does not change the period in progress. It becomes the active ratio when the current period ends.
- R5: When a write and a terminal count fall in the same cycle, the period that starts in that cycle uses the value being written.
- R6: `ref_out` divides `xtal_tick` by 512. It is 1 during the last 256 ticks of each period and falls when the counter wraps.
- R7: `gp_out` equals `div_out` while `test_sel` is 1 and equals `gp_bit` while `test_sel` is 0.
- R8: Each counter moves only in cycles where its own tick input is 1. Otherwise the counter and its output hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One pulse per prescaled oscillator cycle |
| xtal_tick | input | 1 | One pulse per crystal cycle |
| ratio_wr | input | 1 | Write strobe for the programmable ratio |
| ratio_in | input | 15 | Ratio value to write |
| test_sel | input | 1 | Routes the divided oscillator signal to `gp_out` |
| gp_bit | input | 1 | Level driven on `gp_out` when the test route is off |
| div_out | output | 1 | Divided oscillator signal for the phase detector |
| ref_out | output | 1 | Divided reference signal for the phase detector |
| gp_out | output | 1 | General-purpose output / test tap |

## Verification
The critical overlap is a ratio write landing in the same cycle as a terminal count of the programmable divider. The bench provokes it by keeping `osc_tick` high continuously and asserting the write strobe exactly when its own model counter reaches zero. It then checks that the new period has the freshly written length rather than the stale pending value. Writes in the middle of a period, clamped writes and stalled ticks are compared against the same behavioural model on every clock.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
   // Default geometry of the divider chain
   localparam int SD_N_WIDTH_DEF = 15;
   localparam int SD_N_MIN_DEF   = 256;
   localparam int SD_REF_DIV_DEF = 512;

   // Variant selector for the fixed divider
   typedef enum logic {SD_REF_WRAP = 1'b0, SD_REF_RELOAD = 1'b1} sd_ref_kind_e;

   function automatic bit sd_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sd_ratio_reg.sv
module sd_ratio_reg #(
   parameter int N_WIDTH = 15,
   parameter int N_MIN   = 256
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr,
   input  logic [N_WIDTH-1:0] wr_val,
   output logic [N_WIDTH-1:0] pend_o,
   output logic [N_WIDTH-1:0] next_o
);
   localparam logic [N_WIDTH-1:0] MIN_V = N_WIDTH'(N_MIN);

   logic [N_WIDTH-1:0] pend_q;
   logic [N_WIDTH-1:0] clamped;

   always_comb begin
      clamped = (wr_val < MIN_V) ? MIN_V : wr_val;
      next_o  = wr ? clamped : pend_q;
   end

   always_ff @(posedge clk) begin
      if (rst)     pend_q <= MIN_V;
      else if (wr) pend_q <= clamped;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/sd_prog_div.sv
module sd_prog_div #(
   parameter int N_WIDTH = 15,
   parameter int N_MIN   = 256
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic [N_WIDTH-1:0] next_ratio,
   output logic [N_WIDTH-1:0] cnt_o,
   output logic [N_WIDTH-1:0] act_o,
   output logic               div_o
);
   localparam logic [N_WIDTH-1:0] MIN_V = N_WIDTH'(N_MIN);
   localparam logic [N_WIDTH-1:0] ONE   = N_WIDTH'(1);

   logic [N_WIDTH-1:0] cnt_q;
   logic [N_WIDTH-1:0] act_q;
   logic               term;

   assign term = tick && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= MIN_V - ONE;
         act_q <= MIN_V;
      end else if (term) begin
         cnt_q <= next_ratio - ONE;
         act_q <= next_ratio;
      end else if (tick) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign cnt_o = cnt_q;
   assign act_o = act_q;
   assign div_o = (cnt_q < (act_q >> 1));
endmodule

// File: rtl/sd_fixed_div.sv
module sd_fixed_div #(
   parameter int DIV = 512,
   localparam int W  = (DIV > 2) ? $clog2(DIV) : 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick,
   output logic [W-1:0] cnt_o,
   output logic         div_o
);
   import synth_div_pkg::*;

   localparam logic [W-1:0] TOP  = W'(DIV - 1);
   localparam logic [W-1:0] HALF = W'(DIV / 2);
   localparam sd_ref_kind_e KIND = sd_is_pow2(DIV) ? SD_REF_WRAP : SD_REF_RELOAD;

   logic [W-1:0] cnt_q;

   generate
      if (KIND == SD_REF_WRAP) begin : g_wrap
         // power-of-two ratio: natural wrap of the down-counter
         always_ff @(posedge clk) begin
            if (rst)       cnt_q <= TOP;
            else if (tick) cnt_q <= cnt_q - W'(1);
         end
      end else begin : g_reload
         always_ff @(posedge clk) begin
            if (rst)                        cnt_q <= TOP;
            else if (tick && cnt_q == '0)   cnt_q <= TOP;
            else if (tick)                  cnt_q <= cnt_q - W'(1);
         end
      end
   endgenerate

   assign cnt_o = cnt_q;
   assign div_o = (cnt_q < HALF);
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain #(
   parameter int N_WIDTH = synth_div_pkg::SD_N_WIDTH_DEF,
   parameter int N_MIN   = synth_div_pkg::SD_N_MIN_DEF,
   parameter int REF_DIV = synth_div_pkg::SD_REF_DIV_DEF,
   localparam int REF_W  = (REF_DIV > 2) ? $clog2(REF_DIV) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               osc_tick,
   input  logic               xtal_tick,
   input  logic               ratio_wr,
   input  logic [N_WIDTH-1:0] ratio_in,
   input  logic               test_sel,
   input  logic               gp_bit,
   output logic               div_out,
   output logic               ref_out,
   output logic               gp_out
);
   // elaboration-time parameter checks
   if (N_MIN < 2 || N_MIN >= (2 ** N_WIDTH)) begin : g_bad_nmin
      $error("N_MIN must lie in 2 .. 2**N_WIDTH-1");
   end
   if (REF_DIV < 2) begin : g_bad_ref
      $error("REF_DIV must be at least 2");
   end

   logic [N_WIDTH-1:0] ratio_pend;
   logic [N_WIDTH-1:0] ratio_next;
   logic [N_WIDTH-1:0] ratio_act;
   logic [N_WIDTH-1:0] div_cnt;
   logic [REF_W-1:0]   ref_cnt;

   sd_ratio_reg #(.N_WIDTH(N_WIDTH), .N_MIN(N_MIN)) u_ratio (
      .clk    (clk),
      .rst    (rst),
      .wr     (ratio_wr),
      .wr_val (ratio_in),
      .pend_o (ratio_pend),
      .next_o (ratio_next)
   );

   sd_prog_div #(.N_WIDTH(N_WIDTH), .N_MIN(N_MIN)) u_prog (
      .clk        (clk),
      .rst        (rst),
      .tick       (osc_tick),
      .next_ratio (ratio_next),
      .cnt_o      (div_cnt),
      .act_o      (ratio_act),
      .div_o      (div_out)
   );

   sd_fixed_div #(.DIV(REF_DIV)) u_ref (
      .clk   (clk),
      .rst   (rst),
      .tick  (xtal_tick),
      .cnt_o (ref_cnt),
      .div_o (ref_out)
   );

   assign gp_out = test_sel ? div_out : gp_bit;
endmodule

// File: rtl/synth_div_chain_chk.sv
module synth_div_chain_chk #(
   parameter int N_WIDTH = 15,
   parameter int N_MIN   = 256,
   parameter int REF_DIV = 512,
   parameter int REF_W   = 9
) (
   input logic               clk,
   input logic               rst,
   input logic               osc_tick,
   input logic               xtal_tick,
   input logic               test_sel,
   input logic               gp_bit,
   input logic               div_out,
   input logic               gp_out,
   input logic [N_WIDTH-1:0] div_cnt,
   input logic [N_WIDTH-1:0] ratio_act,
   input logic [N_WIDTH-1:0] ratio_pend,
   input logic [REF_W-1:0]   ref_cnt
);
   assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (ratio_act == N_WIDTH'(N_MIN) && ratio_pend == N_WIDTH'(N_MIN)));

   assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
      div_cnt < ratio_act);

   assert_pend_floor_R3: assert property (@(posedge clk) disable iff (rst)
      ratio_pend >= N_WIDTH'(N_MIN));

   assert_act_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(ratio_act) |-> $past(osc_tick && div_cnt == '0));

   assert_ref_range_R6: assert property (@(posedge clk) disable iff (rst)
      32'(ref_cnt) < REF_DIV);

   assert_gp_route_R7: assert property (@(posedge clk) disable iff (rst)
      gp_out == (test_sel ? div_out : gp_bit));

   assert_div_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !osc_tick |=> $stable(div_cnt));

   assert_ref_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !xtal_tick |=> $stable(ref_cnt));
endmodule

bind synth_div_chain synth_div_chain_chk #(
   .N_WIDTH (N_WIDTH),
   .N_MIN   (N_MIN),
   .REF_DIV (REF_DIV),
   .REF_W   (REF_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .osc_tick   (osc_tick),
   .xtal_tick  (xtal_tick),
   .test_sel   (test_sel),
   .gp_bit     (gp_bit),
   .div_out    (div_out),
   .gp_out     (gp_out),
   .div_cnt    (div_cnt),
   .ratio_act  (ratio_act),
   .ratio_pend (ratio_pend),
   .ref_cnt    (ref_cnt)
);

// File: tb/synth_div_chain_tb.sv
`timescale 1ns/1ps
module synth_div_chain_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        osc_tick = 1'b0;
   logic        xtal_tick = 1'b0;
   logic        ratio_wr = 1'b0;
   logic [14:0] ratio_in = '0;
   logic        test_sel = 1'b0;
   logic        gp_bit = 1'b0;
   logic        div_out, ref_out, gp_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit armed = 0;
   bit done = 0;
   string phase = "R1";

   // behavioural reference state
   int m_cnt, m_act, m_pend, m_ref;

   always #5 clk = ~clk;

   synth_div_chain u_dut (
      .clk(clk), .rst(rst), .osc_tick(osc_tick), .xtal_tick(xtal_tick),
      .ratio_wr(ratio_wr), .ratio_in(ratio_in), .test_sel(test_sel),
      .gp_bit(gp_bit), .div_out(div_out), .ref_out(ref_out), .gp_out(gp_out)
   );

   always @(posedge clk) begin
      int nxt;
      if (rst) begin
         m_cnt = 255; m_act = 256; m_pend = 256; m_ref = 511;
      end else begin
         nxt = m_pend;
         if (ratio_wr) begin
            nxt = (int'(ratio_in) < 256) ? 256 : int'(ratio_in);
            m_pend = nxt;
         end
         if (osc_tick) begin
            if (m_cnt == 0) begin m_act = nxt; m_cnt = nxt - 1; end
            else m_cnt = m_cnt - 1;
         end
         if (xtal_tick) m_ref = (m_ref == 0) ? 511 : m_ref - 1;
      end
      armed = 1;
   end

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (armed && !done) begin
         logic e_div;
         e_div = (m_cnt < m_act / 2);
         check(phase, "div_out", div_out, e_div);
         check("R6", "ref_out", ref_out, m_ref < 256);
         check("R7", "gp_out", gp_out, test_sel ? e_div : gp_bit);
      end
   end

   task automatic step(input int n);
      repeat (n) begin
         @(negedge clk); #1;
         ratio_wr = 1'b0;
      end
   endtask

   task automatic write_ratio(input int v);
      @(negedge clk); #1;
      ratio_wr = 1'b1; ratio_in = 15'(v);
      @(negedge clk); #1;
      ratio_wr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(1_900_000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired t=%0t", $time);
      finish_run();
   end

   initial begin
      phase = "R1";
      step(5);
      check("R1", "div_out after reset", div_out, 1'b0);
      check("R1", "ref_out after reset", ref_out, 1'b0);
      @(negedge clk); #1;
      rst = 1'b0; osc_tick = 1'b1; xtal_tick = 1'b1;

      phase = "R2";
      for (int i = 0; i < 800; i++) begin
         step(1);
         gp_bit = (i % 37) < 10;
      end

      phase = "R3";
      write_ratio(10);
      step(700);
      write_ratio(0);
      step(600);

      phase = "R4";
      step(50);
      write_ratio(300);
      step(1000);
      test_sel = 1'b1;
      write_ratio(257);
      for (int i = 0; i < 2500; i++) begin
         step(1);
         osc_tick = ($urandom % 4) != 0;
         xtal_tick = ($urandom % 3) != 0;
      end
      osc_tick = 1'b1; xtal_tick = 1'b1;

      phase = "R5";
      write_ratio(900);
      step(5);
      // wait until the model sits at terminal count, then write in that cycle
      while (m_cnt != 0) step(1);
      ratio_wr = 1'b1; ratio_in = 15'd1000;
      step(1);
      step(2500);

      phase = "R8";
      osc_tick = 1'b0; xtal_tick = 1'b0;
      for (int i = 0; i < 200; i++) begin
         step(1);
         gp_bit = i[3];
      end
      test_sel = 1'b0;
      osc_tick = 1'b1; xtal_tick = 1'b1;

      phase = "R2";
      write_ratio(32767);
      step(34500);
      write_ratio(511);
      step(1200);
      finish_run();
   end
endmodule